// File: doc/BRIEF.md
# DMA Channel Address Register Set

This block keeps the memory address for each channel of a multi-channel DMA engine. Every channel has two 16-bit address registers. The working register is the one the engine steps through during a transfer. The reload register keeps the value the host programmed. Both registers are reached over an 8-bit host port. A single byte-select flag, shared by all channels, decides whether a port access touches the low or the high byte. The flag flips after every port access, and a separate clear command sends it back to the low byte.

Each channel has a step pulse. The pulse moves the working address by one, up or down according to that channel's direction input, and the address wraps at the 16-bit boundary. When a channel has automatic reload enabled, a terminal-count or end-of-process pulse copies the reload register back into the working register. The block joins each working address with two page bytes supplied per channel into a 32-bit address. Its low 24 bits form the legacy 24-bit address. A reset or a master-clear command zeroes all addresses and the byte-select flag.

Top module: `dma_addr_bank`

## Requirements
- R1: After reset, or one clock after a `mclr` pulse, every channel's working and reload address is 0000h, and the byte-select flag points at the low byte.
- R2: The byte-select flag starts at low (bits 7:0). It toggles on every clock with `host_wr` or `host_rd` high, and `clr_ptr` forces it to low. `clr_ptr` wins over an access in the same clock.
- R3: A host write loads `host_wdata` into the selected byte of both the working and the reload register of channel `host_sel`. The other byte is left unchanged.
- R4: `host_rdata` is combinational. It shows the selected byte of the working register of channel `host_sel`, so a read never returns the reload register.
- R5: A `step` pulse with `dir_down` low adds one to that channel's working address, visible on `full_addr` the clock after. FFFFh becomes 0000h.
- R6: A `step` pulse with `dir_down` high subtracts one. 0000h becomes FFFFh.
- R7: A `tc_eop` pulse with `auto_en` high reloads the working address from the reload register on the next clock. The reload takes priority over a `step` pulse in the same clock.
- R8: A `tc_eop` pulse with `auto_en` low leaves the working address unchanged.
- R9: When a host write and a `step` pulse hit the same channel in one clock, the write result is stored and the step is dropped.
- R10: `full_addr` for channel k sits at bits [32k+31:32k] and equals {hi_page byte k, lo_page byte k, working address k}. Wrapping the address never changes the page bytes.
- R11: A step, reload or write on one channel leaves every other channel's address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Master clear pulse |
| clr_ptr | input | 1 | Return byte-select flag to low byte |
| host_sel | input | 3 | Channel index of host access |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| step | input | 8 | Per-channel transfer step pulse |
| dir_down | input | 8 | Per-channel direction, 1 = decrement |
| tc_eop | input | 8 | Per-channel terminal count / end-of-process pulse |
| auto_en | input | 8 | Per-channel automatic reload enable |
| lo_page | input | 64 | Per-channel bits 23:16, byte k at [8k+7:8k] |
| hi_page | input | 64 | Per-channel bits 31:24, byte k at [8k+7:8k] |
| full_addr | output | 256 | Per-channel 32-bit address |

## Verification
Properties check on every clock that the byte flag toggles on each access and returns low after a clear or master clear. They also check that every unopposed step moves the working address by exactly one in the requested direction, and that a reload lands on the stored reload value. The bench scenarios cover the rest. They show that writes reach the hidden reload register, which is only observable later through a reload. They also show that a read returns the working value rather than the reload value, that a write beats a simultaneous step, and how the page bytes attach to the address.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
   // update source selected for a channel's working register in one clock
   typedef enum logic [1:0] {
      UPD_HOLD   = 2'd0,
      UPD_WRITE  = 2'd1,
      UPD_RELOAD = 2'd2,
      UPD_STEP   = 2'd3
   } upd_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic mclr,
   input  logic clr,
   input  logic access,
   output logic ptr_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ptr_hi <= 1'b0;
      else if (mclr || clr)  ptr_hi <= 1'b0;
      else if (access)       ptr_hi <= ~ptr_hi;
   end

   p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !clr && !mclr) |=> (ptr_hi != $past(ptr_hi)));
   p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || mclr) |=> !ptr_hi);
endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
   import dma_addr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclr,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              step,
   input  logic              dir_down,
   input  logic              tc_eop,
   input  logic              auto_en,
   output logic [ADDR_W-1:0] cur
);
   localparam int NLANE = ADDR_W / BYTE_W;

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] cur_wr, base_wr, cur_step;
   logic              reload_req;
   upd_e              upd;

   // byte lanes: replace the addressed lane in both registers
   for (genvar b = 0; b < NLANE; b++) begin : g_lane
      logic lane_hit;
      assign lane_hit = (b == int'(wr_hi));
      assign cur_wr [b*BYTE_W +: BYTE_W] = lane_hit ? wr_byte : cur [b*BYTE_W +: BYTE_W];
      assign base_wr[b*BYTE_W +: BYTE_W] = lane_hit ? wr_byte : base[b*BYTE_W +: BYTE_W];
   end

   assign reload_req = tc_eop && auto_en;
   assign cur_step   = dir_down ? (cur - 1'b1) : (cur + 1'b1);

   always_comb begin
      if (wr_en)           upd = UPD_WRITE;
      else if (reload_req) upd = UPD_RELOAD;
      else if (step)       upd = UPD_STEP;
      else                 upd = UPD_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur  <= '0;
         base <= '0;
      end else if (mclr) begin
         cur  <= '0;
         base <= '0;
      end else begin
         case (upd)
            UPD_WRITE: begin
               cur  <= cur_wr;
               base <= base_wr;
            end
            UPD_RELOAD: cur <= base;
            UPD_STEP:   cur <= cur_step;
            default:    cur <= cur;
         endcase
      end
   end

   p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !dir_down && !wr_en && !reload_req && !mclr) |=> (cur == $past(cur) + 1'b1));
   p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dir_down && !wr_en && !reload_req && !mclr) |=> (cur == $past(cur) - 1'b1));
   p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_req && !wr_en && !mclr) |=> (cur == $past(base)));
   p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_eop && !auto_en && !step && !wr_en && !mclr) |=> $stable(cur));
   p_mclr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (cur == '0 && base == '0));
endmodule

// File: rtl/dma_addr_rdmux.sv
module dma_addr_rdmux #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [CH_W-1:0]          sel,
   input  logic                     ptr_hi,
   input  logic [NUM_CH*ADDR_W-1:0] cur_flat,
   output logic [BYTE_W-1:0]        rdata
);
   logic [ADDR_W-1:0] word;

   always_comb begin
      word = '0;
      for (int k = 0; k < NUM_CH; k++)
         if (sel == CH_W'(k)) word = cur_flat[k*ADDR_W +: ADDR_W];
   end

   assign rdata = ptr_hi ? word[BYTE_W +: BYTE_W] : word[0 +: BYTE_W];
endmodule

// File: rtl/dma_addr_bank.sv
module dma_addr_bank #(
   parameter int NUM_CH       = 8,
   parameter int ADDR_W       = 16,
   parameter int BYTE_W       = 8,
   parameter int PAGE_W       = 8,
   parameter bit HIGH_PAGE_EN = 1'b1,
   localparam int CH_W        = $clog2(NUM_CH),
   localparam int FULL_W      = ADDR_W + 2*PAGE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mclr,
   input  logic                     clr_ptr,
   input  logic [CH_W-1:0]          host_sel,
   input  logic                     host_wr,
   input  logic                     host_rd,
   input  logic [BYTE_W-1:0]        host_wdata,
   output logic [BYTE_W-1:0]        host_rdata,
   input  logic [NUM_CH-1:0]        step,
   input  logic [NUM_CH-1:0]        dir_down,
   input  logic [NUM_CH-1:0]        tc_eop,
   input  logic [NUM_CH-1:0]        auto_en,
   input  logic [NUM_CH*PAGE_W-1:0] lo_page,
   input  logic [NUM_CH*PAGE_W-1:0] hi_page,
   output logic [NUM_CH*FULL_W-1:0] full_addr
);
   if (ADDR_W != 2*BYTE_W) begin : g_chk_width
      $error("ADDR_W must be two host bytes wide");
   end
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_chk_ch
      $error("NUM_CH must be a power of two, at least 2");
   end

   logic                     ptr_hi;
   logic [NUM_CH*ADDR_W-1:0] cur_flat;

   dma_byte_ptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .mclr   (mclr),
      .clr    (clr_ptr),
      .access (host_wr || host_rd),
      .ptr_hi (ptr_hi)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic wr_hit;
      assign wr_hit = host_wr && (host_sel == CH_W'(k));

      dma_addr_chan #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .mclr     (mclr),
         .wr_en    (wr_hit),
         .wr_hi    (ptr_hi),
         .wr_byte  (host_wdata),
         .step     (step[k]),
         .dir_down (dir_down[k]),
         .tc_eop   (tc_eop[k]),
         .auto_en  (auto_en[k]),
         .cur      (cur_flat[k*ADDR_W +: ADDR_W])
      );

      if (HIGH_PAGE_EN) begin : g_hp
         assign full_addr[k*FULL_W +: FULL_W] =
            {hi_page[k*PAGE_W +: PAGE_W], lo_page[k*PAGE_W +: PAGE_W], cur_flat[k*ADDR_W +: ADDR_W]};
      end else begin : g_nohp
         assign full_addr[k*FULL_W +: FULL_W] =
            {{PAGE_W{1'b0}}, lo_page[k*PAGE_W +: PAGE_W], cur_flat[k*ADDR_W +: ADDR_W]};
      end

      p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && step[k] && !mclr) |=>
            (cur_flat[k*ADDR_W + int'($past(ptr_hi))*BYTE_W +: BYTE_W] == $past(host_wdata)));
   end

   dma_addr_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rd (
      .sel      (host_sel),
      .ptr_hi   (ptr_hi),
      .cur_flat (cur_flat),
      .rdata    (host_rdata)
   );
endmodule

// File: tb/sim_dma_addr_bank.sv
`timescale 1ns/100ps
module sim_dma_addr_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mclr = 1'b0, clr_ptr = 1'b0;
   logic [2:0]  host_sel = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [7:0]  step = '0, dir_down = '0, tc_eop = '0, auto_en = '0;
   logic [63:0] lo_page = '0, hi_page = '0;
   logic [255:0] full_addr;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   dma_addr_bank u0 (.*);

   // {op, ch, byte}: op 0 = clear pointer, 1 = write, 2 = read and compare
   localparam logic [12:0] VEC [0:13] = '{
      {2'd0,3'd0,8'h00}, {2'd1,3'd2,8'h34}, {2'd1,3'd2,8'h12},
      {2'd0,3'd0,8'h00}, {2'd2,3'd2,8'h34}, {2'd2,3'd2,8'h12},
      {2'd1,3'd5,8'hCD}, {2'd1,3'd5,8'hAB}, {2'd2,3'd5,8'hCD},
      {2'd2,3'd5,8'hAB}, {2'd2,3'd0,8'h00}, {2'd2,3'd0,8'h00},
      {2'd2,3'd2,8'h34}, {2'd2,3'd2,8'h12}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] addr_of(input int ch);
      return full_addr[ch*32 +: 32];
   endfunction

   task automatic do_clr();
      @(negedge clk) clr_ptr = 1'b1;
      @(negedge clk) clr_ptr = 1'b0;
   endtask

   task automatic do_wr(input int ch, input logic [7:0] d);
      @(negedge clk) begin host_wr = 1'b1; host_sel = 3'(ch); host_wdata = d; end
      @(negedge clk) host_wr = 1'b0;
   endtask

   task automatic do_rd(input int ch, input logic [7:0] exp, input string req);
      @(negedge clk) begin host_rd = 1'b1; host_sel = 3'(ch); end
      #1 chk(req, {24'h0, host_rdata}, {24'h0, exp});
      @(negedge clk) host_rd = 1'b0;
   endtask

   task automatic do_word(input int ch, input logic [15:0] w);
      do_clr();
      do_wr(ch, w[7:0]);
      do_wr(ch, w[15:8]);
   endtask

   task automatic pulse(input int ch, input bit st, input bit tc);
      @(negedge clk) begin step[ch] = st; tc_eop[ch] = tc; end
      @(negedge clk) begin step[ch] = 1'b0; tc_eop[ch] = 1'b0; end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk("R1 reset addr ch0", addr_of(0), 32'h0);
      chk("R1 reset addr ch7", addr_of(7), 32'h0);
      do_rd(0, 8'h00, "R1 reset read");

      // R2 R3 R4 table walk
      foreach (VEC[i]) begin
         case (VEC[i][12:11])
            2'd0: do_clr();
            2'd1: do_wr(int'(VEC[i][10:8]), VEC[i][7:0]);
            default: do_rd(int'(VEC[i][10:8]), VEC[i][7:0], "R2/R3/R4 table");
         endcase
      end

      // R5 R10 wrap up with pages
      lo_page[15:8] = 8'h5A; hi_page[15:8] = 8'hC3;
      do_word(1, 16'hFFFE);
      pulse(1, 1'b1, 1'b0);
      chk("R5 step up", addr_of(1), 32'hC35AFFFF);
      pulse(1, 1'b1, 1'b0);
      chk("R5 R10 wrap up keeps pages", addr_of(1), 32'hC35A0000);

      // R6 down wrap
      dir_down[3] = 1'b1;
      do_word(3, 16'h0001);
      pulse(3, 1'b1, 1'b0);
      chk("R6 step down", addr_of(3), 32'h00000000);
      pulse(3, 1'b1, 1'b0);
      chk("R6 wrap down", addr_of(3), 32'h0000FFFF);
      chk("R11 ch1 untouched", addr_of(1), 32'hC35A0000);

      // R7 reload with step in same cycle, R4 read of working value
      auto_en[4] = 1'b1;
      do_word(4, 16'h1000);
      repeat (3) pulse(4, 1'b1, 1'b0);
      chk("R7 pre reload", addr_of(4), 32'h00001003);
      do_clr();
      do_rd(4, 8'h03, "R4 read returns working");
      pulse(4, 1'b1, 1'b1);
      chk("R7 reload beats step", addr_of(4), 32'h00001000);

      // R8 no reload when disabled
      auto_en[4] = 1'b0;
      pulse(4, 1'b1, 1'b0);
      pulse(4, 1'b0, 1'b1);
      chk("R8 tc without auto", addr_of(4), 32'h00001001);

      // R9 write beats step, and lands in reload register
      do_word(6, 16'h0010);
      do_clr();
      @(negedge clk) begin host_wr = 1'b1; host_sel = 3'd6; host_wdata = 8'h77; step[6] = 1'b1; end
      @(negedge clk) begin host_wr = 1'b0; step[6] = 1'b0; end
      chk("R9 write wins", addr_of(6), 32'h00000077);
      auto_en[6] = 1'b1;
      pulse(6, 1'b1, 1'b0);
      pulse(6, 1'b0, 1'b1);
      chk("R3 R9 reload register took write", addr_of(6), 32'h00000077);

      // R2 clear beats access
      do_clr();
      @(negedge clk) begin clr_ptr = 1'b1; host_wr = 1'b1; host_sel = 3'd7; host_wdata = 8'h11; end
      @(negedge clk) begin clr_ptr = 1'b0; host_wr = 1'b0; end
      do_wr(7, 8'h22);
      chk("R2 clear beats access", addr_of(7), 32'h00000022);

      // R1 master clear
      do_wr(7, 8'h99);
      @(negedge clk) mclr = 1'b1;
      @(negedge clk) mclr = 1'b0;
      chk("R1 mclr ch6", addr_of(6), 32'h0);
      chk("R1 mclr ch1 addr", addr_of(1) & 32'hFFFF, 32'h0);
      do_wr(7, 8'h34);
      chk("R1 mclr pointer low", addr_of(7), 32'h00000034);
      pulse(6, 1'b0, 1'b1);
      chk("R1 mclr reload register", addr_of(6), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule